// File: doc/BRIEF.md
# UART DMA Channel Control Register File

This block is the control and status register file of one byte-wide UART DMA channel that moves data through a ring buffer in memory. Software reaches it through a simple 32-bit register port with single-cycle writes and a combinational read. The block holds the channel configuration: buffer base address with an optional 33rd address bit, buffer length, interrupt threshold and interrupt enables. It also runs a four-state control machine (idle, running, flushing, halting) that the memory mover and the pointer block follow.

The pointer block supplies the current valid-byte and free-space counts and a "drained" level that says no bytes are in flight. From these counts the block raises sticky interrupt flags, and it drives one interrupt line. Stopping is a handshake. Software sets the halt bit, the block clears the enable once the datapath reports drained, and software then clears the halt bit. Flush is a busy bit that clears itself and that software polls. A warm reset returns the control state to idle and clears the interrupt state, but it keeps the buffer configuration.

Top module: `uart_dma_chan_regs`

## Requirements
- R1: After reset, every register reads 0, `chan_en`, `flush_busy`, `halt_req`, `ptr_clr` and `irq` are 0, and the state field at offset 0x50 reads 0 (state codes: 0 idle, 1 running, 2 flushing, 3 halting).
- R2: The base address (0x1C, ADDR_W bits), address extension (0x54, bit 0), length (0x24) and threshold (0x28) read back what was written. Length and threshold keep only their low LEN_W bits. `buf_base` equals {extension bit, base address}.
- R3: A write of 1 to bit 0 of the enable register (0x08) in idle, while the halt bit is 0, starts the channel: enable reads 1 and the state reads 1. A write of 0 to the enable register returns the channel to idle with enable 0. `chan_en` rises only after such a write.
- R4: A write of 1 to bit 0 of the flush register (0x14) makes it read 1 and state 2 from the next cycle. It stays 1 while `drained` is low. The cycle after `drained` is sampled high, it reads 0 and the channel returns to its prior state.
- R5: A write of 1 to the halt register (0x10) while running gives state 3 with `halt_req` high and enable still 1. The cycle after `drained` is sampled high, enable reads 0 and the state reads idle. The halt bit keeps reading 1 until software writes 0.
- R6: While the halt bit reads 1, a write of 1 to the enable register has no effect.
- R7: A write with bit 0 set to the warm-reset register (0x0C) clears enable, halt, flush, the interrupt enables (0x04) and the interrupt flags (0x00), returns the state to idle and pulses `ptr_clr` for one cycle. Base, length, threshold and extension keep their values.
- R8: While enabled, flag bit 0 is set when the byte count reaches the threshold. In receive mode (`dir_rx`=1) that count is `valid_cnt`; in transmit mode it is `free_cnt`. In receive mode, flag bit 1 is set when `valid_cnt` reaches a nonzero length. No flag is set while the channel is disabled.
- R9: In receive mode, writing 1 to a flag bit clears that bit. In transmit mode, a flag write with bit 0 equal to 0 clears bit 0. A clear takes priority over a set in the same cycle. Writes that clear nothing leave the flags unchanged.
- R10: `irq` is high exactly when some flag bit and the matching enable bit at 0x04 are both 1.
- R11: Offset 0x3C reads `valid_cnt` and offset 0x40 reads `free_cnt`. The warm-reset register, the ring pointer offsets 0x2C and 0x30, and every unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dir_rx | input | 1 | 1: receive (device to memory), 0: transmit |
| valid_cnt | input | LEN_W | Bytes in the ring that are ready to be consumed |
| free_cnt | input | LEN_W | Bytes of free space in the ring |
| drained | input | 1 | Datapath has no bytes in flight |
| chan_en | output | 1 | Channel enable |
| flush_busy | output | 1 | Flush in progress |
| halt_req | output | 1 | Halt handshake waiting for drain |
| ptr_clr | output | 1 | One-cycle pointer clear after warm reset |
| buf_base | output | ADDR_W+1 | Buffer base address with extension bit on top |
| buf_len | output | LEN_W | Buffer length |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LEN_W=8 and ADDR_W=32. An 8-bit length lets a 9-bit write show the truncation to LEN_W bits, and it puts the full-buffer flag at a count of 255. A 32-bit address together with the extension bit shows the full 33-bit `buf_base` on the output. The drain input is held low and then released, so the flush and halt states can be seen both while they wait and in the cycle they finish.

// File: rtl/udma_ctl_pkg.sv
package udma_ctl_pkg;

    localparam int DW   = 32;
    localparam int OFSW = 8;

    // register byte offsets
    localparam logic [OFSW-1:0] OFS_FLAG  = 8'h00;
    localparam logic [OFSW-1:0] OFS_IEN   = 8'h04;
    localparam logic [OFSW-1:0] OFS_EN    = 8'h08;
    localparam logic [OFSW-1:0] OFS_WRST  = 8'h0C;
    localparam logic [OFSW-1:0] OFS_HALT  = 8'h10;
    localparam logic [OFSW-1:0] OFS_FLUSH = 8'h14;
    localparam logic [OFSW-1:0] OFS_BASE  = 8'h1C;
    localparam logic [OFSW-1:0] OFS_LEN   = 8'h24;
    localparam logic [OFSW-1:0] OFS_THR   = 8'h28;
    localparam logic [OFSW-1:0] OFS_WPTR  = 8'h2C;
    localparam logic [OFSW-1:0] OFS_RPTR  = 8'h30;
    localparam logic [OFSW-1:0] OFS_VALID = 8'h3C;
    localparam logic [OFSW-1:0] OFS_FREE  = 8'h40;
    localparam logic [OFSW-1:0] OFS_DBG   = 8'h50;
    localparam logic [OFSW-1:0] OFS_EXT   = 8'h54;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_HALT  = 2'd3
    } ctl_state_e;

    // decoded write command for one cycle
    typedef struct packed {
        logic       en_wr;
        logic       halt_wr;
        logic       flush_go;
        logic       wrst;
        logic       flag_wr;
        logic       ien_wr;
        logic [1:0] low2;
    } wr_cmd_t;

    function automatic logic ofs_hit(input logic [OFSW-1:0] a, input logic [OFSW-1:0] ofs);
        return a == ofs;
    endfunction

endpackage

// File: rtl/udma_cfg_bank.sv
module udma_cfg_bank
    import udma_ctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [OFSW-1:0]       reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    input  wr_cmd_t               cmd,
    output logic [ADDR_W-1:0]     base_lo,
    output logic                  ext,
    output logic [LEN_W-1:0]      len,
    output logic [LEN_W-1:0]      thre,
    output logic [1:0]            ien
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo <= '0;
            ext     <= 1'b0;
            len     <= '0;
            thre    <= '0;
            ien     <= '0;
        end else begin
            if (reg_wr && ofs_hit(reg_addr, OFS_BASE)) base_lo <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && ofs_hit(reg_addr, OFS_EXT))  ext     <= reg_wdata[0];
            if (reg_wr && ofs_hit(reg_addr, OFS_LEN))  len     <= reg_wdata[LEN_W-1:0];
            if (reg_wr && ofs_hit(reg_addr, OFS_THR))  thre    <= reg_wdata[LEN_W-1:0];
            // warm reset drops interrupt enables, keeps buffer setup
            if (cmd.wrst)        ien <= '0;
            else if (cmd.ien_wr) ien <= cmd.low2;
        end
    end

endmodule

// File: rtl/udma_ctl_fsm.sv
module udma_ctl_fsm
    import udma_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_cmd_t    cmd,
    input  logic       drained,
    output logic       en,
    output logic       halt,
    output ctl_state_e state
);

    ctl_state_e state_n;
    logic       en_n;
    logic       halt_n;

    always_comb begin
        state_n = state;
        en_n    = en;
        halt_n  = cmd.halt_wr ? cmd.low2[0] : halt;
        unique case (state)
            ST_IDLE: begin
                if (cmd.flush_go) begin
                    state_n = ST_FLUSH;
                end else if (cmd.en_wr && cmd.low2[0] && !halt) begin
                    state_n = ST_RUN;
                    en_n    = 1'b1;
                end
            end
            ST_RUN: begin
                if (cmd.en_wr && !cmd.low2[0]) begin
                    state_n = ST_IDLE;
                    en_n    = 1'b0;
                end else if (cmd.flush_go) begin
                    state_n = ST_FLUSH;
                end else if (cmd.halt_wr && cmd.low2[0]) begin
                    state_n = ST_HALT;
                end
            end
            ST_FLUSH: begin
                if (cmd.en_wr && !cmd.low2[0]) en_n = 1'b0;
                if (drained) begin
                    if (!en_n)       state_n = ST_IDLE;
                    else if (halt_n) state_n = ST_HALT;
                    else             state_n = ST_RUN;
                end
            end
            ST_HALT: begin
                if (drained || (cmd.en_wr && !cmd.low2[0])) begin
                    state_n = ST_IDLE;
                    en_n    = 1'b0;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.wrst) begin
            state <= ST_IDLE;
            en    <= 1'b0;
            halt  <= 1'b0;
        end else begin
            state <= state_n;
            en    <= en_n;
            halt  <= halt_n;
        end
    end

endmodule

// File: rtl/udma_irq_unit.sv
module udma_irq_unit
    import udma_ctl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic             dir_rx,
    input  logic             en,
    input  logic [1:0]       ien,
    input  logic [LEN_W-1:0] thre,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] valid_cnt,
    input  logic [LEN_W-1:0] free_cnt,
    output logic [1:0]       flags,
    output logic             irq
);

    localparam int NFLAG = 2;

    logic [LEN_W-1:0] lvl_cnt;
    logic [NFLAG-1:0] cond;
    logic [NFLAG-1:0] clr;

    assign lvl_cnt = dir_rx ? valid_cnt : free_cnt;
    assign cond[0] = lvl_cnt >= thre;
    assign cond[1] = dir_rx && (len != '0) && (valid_cnt >= len);

    // receive: write one to clear; transmit: bit 0 written as zero clears
    assign clr[0] = cmd.flag_wr && (dir_rx ? cmd.low2[0] : !cmd.low2[0]);
    assign clr[1] = cmd.flag_wr && (dir_rx ? cmd.low2[1] : 1'b1);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || cmd.wrst)  flags[i] <= 1'b0;
            else if (clr[i])      flags[i] <= 1'b0;
            else if (en && cond[i]) flags[i] <= 1'b1;
        end
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/uart_dma_chan_regs.sv
module uart_dma_chan_regs
    import udma_ctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dir_rx,
    input  logic [LEN_W-1:0]  valid_cnt,
    input  logic [LEN_W-1:0]  free_cnt,
    input  logic              drained,
    output logic              chan_en,
    output logic              flush_busy,
    output logic              halt_req,
    output logic              ptr_clr,
    output logic [ADDR_W:0]   buf_base,
    output logic [LEN_W-1:0]  buf_len,
    output logic              irq
);

    wr_cmd_t          cmd;
    logic [ADDR_W-1:0] base_lo;
    logic             ext;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] thre;
    logic [1:0]       ien;
    logic [1:0]       flags;
    logic             en;
    logic             halt;
    ctl_state_e       state;

    always_comb begin
        cmd          = '0;
        cmd.low2     = reg_wdata[1:0];
        cmd.en_wr    = reg_wr && ofs_hit(reg_addr, OFS_EN);
        cmd.halt_wr  = reg_wr && ofs_hit(reg_addr, OFS_HALT);
        cmd.flush_go = reg_wr && ofs_hit(reg_addr, OFS_FLUSH) && reg_wdata[0];
        cmd.wrst     = reg_wr && ofs_hit(reg_addr, OFS_WRST) && reg_wdata[0];
        cmd.flag_wr  = reg_wr && ofs_hit(reg_addr, OFS_FLAG);
        cmd.ien_wr   = reg_wr && ofs_hit(reg_addr, OFS_IEN);
    end

    udma_cfg_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .cmd      (cmd),
        .base_lo  (base_lo),
        .ext      (ext),
        .len      (len),
        .thre     (thre),
        .ien      (ien)
    );

    udma_ctl_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .drained(drained),
        .en     (en),
        .halt   (halt),
        .state  (state)
    );

    udma_irq_unit #(.LEN_W(LEN_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .dir_rx   (dir_rx),
        .en       (en),
        .ien      (ien),
        .thre     (thre),
        .len      (len),
        .valid_cnt(valid_cnt),
        .free_cnt (free_cnt),
        .flags    (flags),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) ptr_clr <= 1'b0;
        else     ptr_clr <= cmd.wrst;
    end

    assign chan_en    = en;
    assign flush_busy = (state == ST_FLUSH);
    assign halt_req   = (state == ST_HALT);
    assign buf_base   = {ext, base_lo};
    assign buf_len    = len;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_FLAG:  reg_rdata[1:0]       = flags;
            OFS_IEN:   reg_rdata[1:0]       = ien;
            OFS_EN:    reg_rdata[0]         = en;
            OFS_HALT:  reg_rdata[0]         = halt;
            OFS_FLUSH: reg_rdata[0]         = flush_busy;
            OFS_BASE:  reg_rdata[ADDR_W-1:0] = base_lo;
            OFS_LEN:   reg_rdata[LEN_W-1:0] = len;
            OFS_THR:   reg_rdata[LEN_W-1:0] = thre;
            OFS_VALID: reg_rdata[LEN_W-1:0] = valid_cnt;
            OFS_FREE:  reg_rdata[LEN_W-1:0] = free_cnt;
            OFS_DBG:   reg_rdata[1:0]       = state;
            OFS_EXT:   reg_rdata[0]         = ext;
            default:   reg_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/uart_dma_chan_regs_chk.sv
module uart_dma_chan_regs_chk
    import udma_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        drained,
    input logic        chan_en,
    input logic        flush_busy,
    input logic        halt_req,
    input logic        ptr_clr
);

    // R4
    flush_done_chk: assert property (@(posedge clk) disable iff (rst)
        flush_busy && drained |=> !flush_busy);

    // R5
    halt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req && drained |=> !chan_en && !halt_req);

    // R5
    halt_holds_en_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> chan_en);

    // R7
    warm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == OFS_WRST && reg_wdata[0]
        |=> !chan_en && !flush_busy && !halt_req && ptr_clr);

    // R3
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_en) |-> $past(reg_wr && reg_addr == OFS_EN && reg_wdata[0]));

endmodule

bind uart_dma_chan_regs uart_dma_chan_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .drained   (drained),
    .chan_en   (chan_en),
    .flush_busy(flush_busy),
    .halt_req  (halt_req),
    .ptr_clr   (ptr_clr)
);

// File: tb/uart_dma_chan_regs_test.sv
`timescale 1ns/100ps
module uart_dma_chan_regs_test;

    localparam int LW = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dir_rx = 1'b1;
    logic [LW-1:0] valid_cnt = '0;
    logic [LW-1:0] free_cnt = '0;
    logic          drained = 1'b0;
    logic          chan_en, flush_busy, halt_req, ptr_clr, irq;
    logic [AW:0]   buf_base;
    logic [LW-1:0] buf_len;

    always #2.5 clk = ~clk;

    uart_dma_chan_regs #(.ADDR_W(AW), .LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_rx(dir_rx),
        .valid_cnt(valid_cnt), .free_cnt(free_cnt), .drained(drained),
        .chan_en(chan_en), .flush_busy(flush_busy), .halt_req(halt_req),
        .ptr_clr(ptr_clr), .buf_base(buf_base), .buf_len(buf_len), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // monitor: compares read data with the queued expectation
    initial forever begin
        exp_t e;
        @(negedge clk);
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (reg_rdata !== e.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", e.tag, reg_rdata, e.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] x, input string t);
        reg_addr = a;
        q.push_back('{x, t});
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pin(input logic [63:0] got, input logic [63:0] x, input string t);
        n_chk++;
        if (got !== x) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, got, x);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h08, 0, "R1 enable");
        rd(8'h50, 0, "R1 state");
        rd(8'h00, 0, "R1 flags");
        rd(8'h24, 0, "R1 length");
        pin(irq, 0, "R1 irq");
        pin(chan_en, 0, "R1 chan_en");

        // R2 configuration
        wr(8'h1C, 32'h1234_5678);
        wr(8'h54, 32'h1);
        wr(8'h24, 32'h1FF);
        wr(8'h28, 32'h40);
        rd(8'h24, 32'hFF, "R2 length truncated");
        rd(8'h28, 32'h40, "R2 threshold");
        rd(8'h1C, 32'h1234_5678, "R2 base");
        pin(buf_base, 33'h1_1234_5678, "R2 buf_base");
        pin(buf_len, 8'hFF, "R2 buf_len");

        // R11 status and unmapped reads
        valid_cnt = 8'h33;
        free_cnt  = 8'h77;
        rd(8'h3C, 32'h33, "R11 valid count");
        rd(8'h40, 32'h77, "R11 free count");
        rd(8'h18, 0, "R11 unmapped");
        rd(8'h2C, 0, "R11 write pointer");
        rd(8'h0C, 0, "R11 warm reset reg");
        free_cnt = 0;

        // R3 enable, receive mode
        valid_cnt = 8'h10;
        wr(8'h04, 32'h3);
        wr(8'h08, 32'h1);
        rd(8'h08, 1, "R3 enable");
        rd(8'h50, 1, "R3 state running");
        rd(8'h00, 0, "R8 below threshold");

        // R8 / R10 flag set
        valid_cnt = 8'h40;
        @(negedge clk);
        rd(8'h00, 1, "R8 rx threshold");
        pin(irq, 1, "R10 irq on");
        valid_cnt = 8'hFF;
        @(negedge clk);
        rd(8'h00, 3, "R8 rx full");

        // R9 write one to clear in receive mode
        valid_cnt = 0;
        wr(8'h00, 32'h1);
        rd(8'h00, 2, "R9 rx clear bit0");
        wr(8'h00, 32'h2);
        rd(8'h00, 0, "R9 rx clear bit1");
        wr(8'h04, 32'h0);
        valid_cnt = 8'h40;
        @(negedge clk);
        rd(8'h00, 1, "R8 set with irq masked");
        pin(irq, 0, "R10 irq masked");
        wr(8'h00, 32'h0);
        rd(8'h00, 1, "R9 rx zero write no clear");
        wr(8'h00, 32'h1);
        rd(8'h00, 0, "R9 clear wins");
        rd(8'h00, 1, "R9 set after clear");
        valid_cnt = 0;
        wr(8'h00, 32'h3);

        // R8 / R9 transmit mode
        dir_rx   = 1'b0;
        free_cnt = 8'h10;
        wr(8'h04, 32'h1);
        rd(8'h00, 0, "R8 tx below threshold");
        free_cnt = 8'h40;
        @(negedge clk);
        rd(8'h00, 1, "R8 tx threshold");
        pin(irq, 1, "R10 tx irq");
        wr(8'h00, 32'h1);
        rd(8'h00, 1, "R9 tx write one keeps");
        free_cnt = 0;
        wr(8'h00, 32'h0);
        rd(8'h00, 0, "R9 tx write zero clears");
        pin(irq, 0, "R10 irq off");
        dir_rx = 1'b1;

        // R4 flush
        wr(8'h14, 32'h1);
        pin(flush_busy, 1, "R4 flush_busy");
        rd(8'h14, 1, "R4 flush busy");
        rd(8'h50, 2, "R4 state flushing");
        rd(8'h14, 1, "R4 still busy");
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        rd(8'h14, 0, "R4 flush done");
        rd(8'h50, 1, "R4 back to running");

        // R5 halt handshake
        wr(8'h10, 32'h1);
        rd(8'h50, 3, "R5 state halting");
        rd(8'h08, 1, "R5 enable held");
        pin(halt_req, 1, "R5 halt_req");
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        rd(8'h08, 0, "R5 enable dropped");
        rd(8'h50, 0, "R5 state idle");
        rd(8'h10, 1, "R5 halt bit held");

        // R6 enable blocked while halt bit set
        wr(8'h08, 32'h1);
        rd(8'h08, 0, "R6 enable ignored");
        pin(chan_en, 0, "R6 chan_en");
        wr(8'h10, 32'h0);
        wr(8'h08, 32'h1);
        rd(8'h08, 1, "R3 enable after halt cleared");

        // R7 warm reset
        wr(8'h04, 32'h3);
        wr(8'h14, 32'h1);
        wr(8'h0C, 32'h1);
        pin(ptr_clr, 1, "R7 ptr_clr pulse");
        rd(8'h08, 0, "R7 enable cleared");
        pin(ptr_clr, 0, "R7 ptr_clr single");
        rd(8'h14, 0, "R7 flush cleared");
        rd(8'h04, 0, "R7 int enable cleared");
        rd(8'h50, 0, "R7 state idle");
        rd(8'h1C, 32'h1234_5678, "R7 base kept");
        rd(8'h24, 32'hFF, "R7 length kept");
        rd(8'h54, 1, "R7 ext kept");

        // R3 disable, R8 no set while disabled
        wr(8'h08, 32'h1);
        wr(8'h08, 32'h0);
        rd(8'h08, 0, "R3 disable");
        rd(8'h50, 0, "R3 idle after disable");
        valid_cnt = 8'hFF;
        @(negedge clk);
        rd(8'h00, 0, "R8 no set while disabled");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule